// File: doc/BRIEF.md
# DQS Write Leveling Calibrator

This block finds, for each byte lane of a DDR3-style memory interface, the DQS output delay that puts the strobe's rising edge on the memory clock's rising edge at the device pin. Fly-by routing gives each device a different clock-to-strobe skew. For that reason every lane runs its own search with its own feedback bit.

For each trial delay, the block issues one DQS pulse. The memory samples its clock with the delayed strobe and returns the sampled level asynchronously on a designated DQ line: the first DQ of the lower byte for the lower strobe, and the first DQ of the upper byte for the upper strobe. The block synchronizes this bit and waits a programmable latency. It then takes a short burst of samples and takes a majority vote. A lane locks at the first tap where the vote reads 1 after it has already read 0 at an earlier tap. A lane that reaches the top tap without such a 0-to-1 change is flagged as failed.

The delay line, its I/O and the mode-register sequence that enters leveling mode lie outside this block. It only drives the tap codes and the pulse request, and it consumes the feedback.

Top module: `wrlvl_calib`

## Requirements
- R1: After synchronous reset, every tap code is 0, and `dqs_pulse_o`, `done_o`, every `lane_done_o` bit and every `lane_err_o` bit are low.
- R2: Each trial step produces exactly one `dqs_pulse_o` pulse, one cycle wide. Consecutive pulses are `wait_cycles_i + SAMPLES + 4` cycles apart.
- R3: A calibration starts every enabled lane at tap 0. While the lane searches, its tap advances by exactly 1 per step and never moves by more than 1 in a cycle.
- R4: A lane locks at the first tap whose majority vote is 1 after an earlier tap voted 0. It then raises its `lane_done_o` bit and holds that tap.
- R5: Taps that vote 1 before any tap has voted 0 are skipped. They never cause a lock.
- R6: Feedback passes through a two-stage synchronizer. It is then sampled on SAMPLES (default 3) consecutive cycles, and the vote is 1 only when more than half the samples are 1. A single 1 among the samples is rejected.
- R7: If a lane has not locked by tap 127 (the 7-bit maximum), its `lane_err_o` and `lane_done_o` bits are both set and its tap stays at 127.
- R8: Lanes search independently. Lanes with different feedback lock at different taps within the same run.
- R9: A lane whose `lane_en_i` bit is low at start stays at tap 0 with its done and error bits low. `done_o` rises once every enabled lane is done.
- R10: Tap codes, lane flags and `done_o` stay stable after completion until the next start. A start clears `done_o` and resets enabled taps to 0 on the next cycle.
- R11: A start request while calibration is running is ignored. Taps are not reset and the run finishes with the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request, honoured only when idle |
| lane_en_i | input | NUM_LANES | Per-lane enable, captured at start |
| wait_cycles_i | input | WAIT_W | Feedback latency wait after each pulse |
| fb_async_i | input | NUM_LANES | Asynchronous per-lane feedback bits |
| dqs_pulse_o | output | 1 | Request for one DQS pulse at current taps |
| tap_o | output | NUM_LANES*TAP_W | Per-lane delay tap codes, lane 0 in the low bits |
| lane_done_o | output | NUM_LANES | Lane locked or failed |
| lane_err_o | output | NUM_LANES | Lane found no 0-to-1 change |
| done_o | output | 1 | All enabled lanes finished |

## Verification
If a lane's search state is wrong, the symptom shows up at the ports as a tap that locks one or more steps early or late. It can also show as a wrong pulse count, because every step costs exactly one pulse. A miscounted vote or a leading region treated as valid locks the lane at the wrong tap, and that tap is visible at completion. A broken step timer shows up at the second pulse as wrong pulse spacing. A lane that fails to hold shows as a tap that moves while `done_o` is high, within one cycle.

// File: rtl/wrl_pkg.sv
package wrl_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULSE,
        SQ_WAIT,
        SQ_SAMPLE,
        SQ_EVAL,
        SQ_CHECK
    } seq_state_e;

    typedef enum logic [2:0] {
        LN_OFF,
        LN_SEEK0,
        LN_SEEK1,
        LN_LOCK,
        LN_FAIL
    } lane_state_e;

    typedef struct packed {
        logic clr;
        logic sample;
        logic eval;
    } step_ctl_t;

    function automatic logic vote_high(input int unsigned ones, input int unsigned n);
        return (2 * ones) > n;
    endfunction

endpackage

// File: rtl/wrl_sync.sv
module wrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wrl_seq.sv
module wrl_seq
    import wrl_pkg::*;
#(
    parameter int WAIT_W  = 8,
    parameter int SAMPLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              all_fin_i,
    output step_ctl_t         ctl_o,
    output logic              dqs_pulse_o,
    output logic              done_o
);
    localparam int SCNT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SAMPLES - 1);

    seq_state_e        state_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [SCNT_W-1:0] scnt_q;
    logic              done_q;

    always_comb begin
        ctl_o.clr    = (state_q == SQ_IDLE) && start_i;
        ctl_o.sample = (state_q == SQ_SAMPLE);
        ctl_o.eval   = (state_q == SQ_EVAL);
        dqs_pulse_o  = (state_q == SQ_PULSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wcnt_q  <= '0;
            scnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start_i) begin
                    state_q <= SQ_PULSE;
                    done_q  <= 1'b0;
                end
                SQ_PULSE: begin
                    wcnt_q  <= wait_i;
                    state_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wcnt_q == '0) begin
                        scnt_q  <= '0;
                        state_q <= SQ_SAMPLE;
                    end else begin
                        wcnt_q <= wcnt_q - WAIT_W'(1);
                    end
                end
                SQ_SAMPLE: begin
                    if (scnt_q == SCNT_LAST) state_q <= SQ_EVAL;
                    else                     scnt_q  <= scnt_q + SCNT_W'(1);
                end
                SQ_EVAL:  state_q <= SQ_CHECK;
                SQ_CHECK: begin
                    if (all_fin_i) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= SQ_PULSE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign done_o = done_q;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        dqs_pulse_o |=> !dqs_pulse_o);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/wrl_lane.sv
module wrl_lane
    import wrl_pkg::*;
#(
    parameter int TAP_W   = 7,
    parameter int SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  step_ctl_t        ctl_i,
    input  logic             fb_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             fin_o,
    output logic             err_o,
    output logic             act_o
);
    localparam int ONES_W = $clog2(SAMPLES + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    lane_state_e       state_q;
    logic [TAP_W-1:0]  tap_q;
    logic [ONES_W-1:0] ones_q;
    logic              searching;
    logic              hit;

    assign searching = (state_q == LN_SEEK0) || (state_q == LN_SEEK1);
    assign hit       = vote_high(32'(ones_q), SAMPLES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_OFF;
            tap_q   <= '0;
            ones_q  <= '0;
        end else if (ctl_i.clr) begin
            state_q <= en_i ? LN_SEEK0 : LN_OFF;
            tap_q   <= '0;
            ones_q  <= '0;
        end else begin
            if (ctl_i.sample && searching)
                ones_q <= ones_q + ONES_W'(fb_i);
            if (ctl_i.eval) begin
                ones_q <= '0;
                if (state_q == LN_SEEK1 && hit) begin
                    state_q <= LN_LOCK;
                end else if (searching) begin
                    if (tap_q == TAP_MAX) begin
                        state_q <= LN_FAIL;
                    end else begin
                        tap_q <= tap_q + TAP_W'(1);
                        if (state_q == LN_SEEK0 && !hit) state_q <= LN_SEEK1;
                    end
                end
            end
        end
    end

    assign tap_o = tap_q;
    assign fin_o = (state_q == LN_LOCK) || (state_q == LN_FAIL);
    assign err_o = (state_q == LN_FAIL);
    assign act_o = (state_q != LN_OFF);

    // R3
    tap_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.clr |=> (tap_q == $past(tap_q)) || (tap_q == $past(tap_q) + TAP_W'(1)));

    // R10
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !ctl_i.clr) |=> (fin_o && $stable(tap_q)));

    // R7
    err_tap_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (tap_q == TAP_MAX));

    // R5
    no_early_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LN_SEEK0 && !ctl_i.clr) |=> (state_q != LN_LOCK));
endmodule

// File: rtl/wrlvl_calib.sv
module wrlvl_calib
    import wrl_pkg::*;
#(
    parameter int NUM_LANES   = 2,
    parameter int TAP_W       = 7,
    parameter int WAIT_W      = 8,
    parameter int SAMPLES     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [NUM_LANES-1:0]       lane_en_i,
    input  logic [WAIT_W-1:0]          wait_cycles_i,
    input  logic [NUM_LANES-1:0]       fb_async_i,
    output logic                       dqs_pulse_o,
    output logic [NUM_LANES*TAP_W-1:0] tap_o,
    output logic [NUM_LANES-1:0]       lane_done_o,
    output logic [NUM_LANES-1:0]       lane_err_o,
    output logic                       done_o
);
    step_ctl_t            ctl;
    logic [NUM_LANES-1:0] fb_sync;
    logic [NUM_LANES-1:0] fin;
    logic [NUM_LANES-1:0] act;
    logic                 all_fin;

    assign all_fin = &(fin | ~act);

    wrl_seq #(
        .WAIT_W (WAIT_W),
        .SAMPLES(SAMPLES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .wait_i     (wait_cycles_i),
        .all_fin_i  (all_fin),
        .ctl_o      (ctl),
        .dqs_pulse_o(dqs_pulse_o),
        .done_o     (done_o)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        wrl_sync #(
            .STAGES(SYNC_STAGES)
        ) sync_i (
            .clk(clk),
            .rst(rst),
            .d_i(fb_async_i[l]),
            .q_o(fb_sync[l])
        );

        wrl_lane #(
            .TAP_W  (TAP_W),
            .SAMPLES(SAMPLES)
        ) lane_i (
            .clk  (clk),
            .rst  (rst),
            .en_i (lane_en_i[l]),
            .ctl_i(ctl),
            .fb_i (fb_sync[l]),
            .tap_o(tap_o[l*TAP_W +: TAP_W]),
            .fin_o(fin[l]),
            .err_o(lane_err_o[l]),
            .act_o(act[l])
        );
    end

    assign lane_done_o = fin;

    // R9
    done_all_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> all_fin);
endmodule

// File: tb/wrlvl_calib_tb_top.sv
module wrlvl_calib_tb_top;
    localparam int NL = 2;
    localparam int TW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [NL-1:0] lane_en;
    logic [7:0]    wait_cyc;
    logic [NL-1:0] fb;
    logic          dqs;
    logic [NL*TW-1:0] taps;
    logic [NL-1:0] ldone, lerr;
    logic          done;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int lo_a [NL];
    int hi_b [NL];
    bit noisy[NL];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wrlvl_calib dut_i (
        .clk(clk), .rst(rst), .start_i(start), .lane_en_i(lane_en),
        .wait_cycles_i(wait_cyc), .fb_async_i(fb), .dqs_pulse_o(dqs),
        .tap_o(taps), .lane_done_o(ldone), .lane_err_o(lerr), .done_o(done)
    );

    // Memory feedback model: 1 below lo_a, 0 (or sparse noise) up to hi_b, 1 from hi_b.
    always_comb begin
        for (int l = 0; l < NL; l++) begin
            int t;
            t = int'(taps[l*TW +: TW]);
            if (t < lo_a[l])      fb[l] = 1'b1;
            else if (t < hi_b[l]) fb[l] = noisy[l] ? ((cyc % 4) == 0) : 1'b0;
            else                  fb[l] = 1'b1;
        end
    end

    function automatic int tap_of(int l);
        return int'(taps[l*TW +: TW]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cal(input logic [NL-1:0] en, input int wt, output int pulses, output int bad_gap);
        int last;
        int guard;
        @(negedge clk);
        lane_en  = en;
        wait_cyc = 8'(wt);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 done cleared by start", int'(done), 0);
        for (int l = 0; l < NL; l++) if (en[l]) chk("R3 tap 0 at start", tap_of(l), 0);
        pulses = 0; bad_gap = 0; last = -1; guard = 0;
        while (!done && guard < 20000) begin
            if (dqs) begin
                if (last >= 0 && (guard - last) != wt + 3 + 4) bad_gap++;
                last = guard;
                pulses++;
            end
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; lane_en = '0; wait_cyc = 8'd4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tap0", tap_of(0), 0);
        chk("R1 tap1", tap_of(1), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 lane_done", int'(ldone), 0);
        chk("R1 lane_err", int'(lerr), 0);
        chk("R1 pulse", int'(dqs), 0);
    endtask

    task automatic t_basic;
        int p, g, t0, t1;
        lo_a = '{0, 0}; hi_b = '{5, 9}; noisy = '{0, 0};
        run_cal(2'b11, 4, p, g);
        chk("R4 lane0 lock", tap_of(0), 5);
        chk("R8 lane1 lock", tap_of(1), 9);
        chk("R4 lane_done", int'(ldone), 3);
        chk("R4 no err", int'(lerr), 0);
        chk("R2 pulse count", p, 10);
        chk("R2 pulse spacing wait 4", g, 0);
        t0 = tap_of(0); t1 = tap_of(1);
        repeat (20) @(negedge clk);
        chk("R10 hold tap0", tap_of(0), t0);
        chk("R10 hold tap1", tap_of(1), t1);
        chk("R10 hold done", int'(done), 1);
    endtask

    task automatic t_leading_ones;
        int p, g;
        lo_a = '{3, 200}; hi_b = '{12, 255}; noisy = '{0, 0};
        run_cal(2'b11, 10, p, g);
        chk("R5 skip leading ones lane0", tap_of(0), 12);
        chk("R5 all-ones lane1 fails", int'(lerr[1]), 1);
        chk("R7 fail tap 127", tap_of(1), 127);
        chk("R2 spacing wait 10", g, 0);
        chk("R2 count to max", p, 128);
    endtask

    task automatic t_noise;
        int p, g;
        lo_a = '{0, 0}; hi_b = '{7, 20}; noisy = '{1, 1};
        run_cal(2'b11, 4, p, g);
        chk("R6 vote rejects lone 1 lane0", tap_of(0), 7);
        chk("R6 vote rejects lone 1 lane1", tap_of(1), 20);
        chk("R6 no err", int'(lerr), 0);
    endtask

    task automatic t_error;
        int p, g;
        lo_a = '{0, 0}; hi_b = '{1, 200}; noisy = '{0, 0};
        run_cal(2'b11, 2, p, g);
        chk("R8 lane0 lock", tap_of(0), 1);
        chk("R7 lane1 err", int'(lerr), 2);
        chk("R7 lane1 done", int'(ldone), 3);
        chk("R7 lane1 tap", tap_of(1), 127);
        chk("R9 done", int'(done), 1);
    endtask

    task automatic t_disabled;
        int p, g;
        lo_a = '{0, 0}; hi_b = '{4, 200}; noisy = '{0, 0};
        run_cal(2'b01, 4, p, g);
        chk("R9 lane0 lock", tap_of(0), 4);
        chk("R9 off lane tap", tap_of(1), 0);
        chk("R9 off lane flags", int'({lerr[1], ldone[1]}), 0);
        chk("R9 done", int'(done), 1);
        chk("R9 pulse count", p, 5);
    endtask

    task automatic t_restart_busy;
        int guard, seen;
        lo_a = '{0, 0}; hi_b = '{10, 6}; noisy = '{0, 0};
        @(negedge clk);
        lane_en = 2'b11; wait_cyc = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (tap_of(0) < 3 && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
        seen = tap_of(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 tap not reset", int'(tap_of(0) >= seen && seen >= 3), 1);
        @(negedge clk);
        chk("R11 tap still not reset", int'(tap_of(0) >= seen), 1);
        guard = 0;
        while (!done && guard < 20000) begin
            guard++;
            @(negedge clk);
        end
        chk("R11 lane0 result", tap_of(0), 10);
        chk("R11 lane1 result", tap_of(1), 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        lo_a = '{0, 0}; hi_b = '{0, 0}; noisy = '{0, 0};
        t_reset();
        t_basic();
        t_leading_ones();
        t_noise();
        t_error();
        t_disabled();
        t_restart_busy();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule